// File: doc/BRIEF.md
# Byte-Aligned Test-Clock Shift Controller

This block issues a test-clock enable and shifts several byte-wide buffers in lockstep with it. There are a number of transmit lanes: by default one for outgoing test data and two for mode-select streams. There is also one receive lane that gathers incoming test data. Every lane takes its bit position from one shared bit counter, so all lanes reach a byte boundary on the same cycle. A lane that is switched on partway through a byte sends only the bits that remain before that boundary.

A down-counter sets how many test-clock cycles are issued. Test clocking runs while the run request is high and the counter is nonzero. Each clocked cycle moves every enabled lane by one bit and takes one from the counter. At zero, clocking stops and the counter stays at zero until it is loaded again. A single-step request takes one from the counter without a test-clock cycle and without moving any lane. A synchronous clear command returns the whole block to its reset state.

Top module: `tck_shift_ctrl`

## Requirements
- R1: After reset, `tck_en`, `cnt_value`, every `tx_serial` bit, every byte-done flag and `rx_byte` are all 0.
- R2: `tck_en` is 1 exactly when `run_en` is 1, `cnt_value` is nonzero, and neither `cnt_load` nor `sync_clr` is asserted. Each such cycle lowers `cnt_value` by one. Once the count reaches 0, `tck_en` stays 0 and the count stays 0 until the counter is loaded.
- R3: `cnt_load` writes `cnt_load_val` into the counter at the next edge. This takes priority over counting down, and no test-clock cycle is issued in the load cycle.
- R4: `step_req` in a cycle with no test clocking and a nonzero count lowers the count by one. It issues no test-clock cycle and leaves the bit position and every lane unchanged.
- R5: Transmit lanes shift out least significant bit first. While a lane is enabled, its `tx_serial` bit shows the bit due on the current test-clock cycle.
- R6: A single 3-bit position counter steps on each test-clock cycle and wraps from 7 to 0. The cycle after a test-clock cycle at position 7, each enabled lane raises its byte-done flag for exactly one cycle. A lane enabled at position 3 shifts out 5 bits of its first byte before its flag rises.
- R7: A disabled transmit lane keeps its contents and drives its `tx_serial` bit to 0.
- R8: An enabled receive lane samples `rx_serial_in` on each test-clock cycle. Over one aligned byte, the k-th sampled bit lands in `rx_byte` bit k. A disabled receive lane holds `rx_byte`.
- R9: A `tx_load` bit loads the matching byte of `tx_load_data` into that lane. Lane i uses bits 8i+7 down to 8i. The load takes priority over shifting.
- R10: `sync_clr` clears the counter, the bit position, all lanes and all flags at the next edge. It takes priority over loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of the whole block |
| run_en | input | 1 | Request for test clocking |
| step_req | input | 1 | Single-step the counter without a test-clock cycle |
| cnt_load | input | 1 | Load strobe for the cycle counter |
| cnt_load_val | input | 32 | Value written into the cycle counter |
| cnt_value | output | 32 | Current cycle count |
| tck_en | output | 1 | Test-clock enable for this cycle |
| tx_en | input | 3 | Enable for each transmit lane |
| tx_load | input | 3 | Load strobe for each transmit lane |
| tx_load_data | input | 24 | Load bytes, lane i in bits 8i+7:8i |
| tx_serial | output | 3 | Serial bit of each transmit lane |
| tx_byte_done | output | 3 | Byte-complete pulse of each transmit lane |
| rx_en | input | 1 | Enable for the receive lane |
| rx_serial_in | input | 1 | Serial input of the receive lane |
| rx_byte | output | 8 | Contents of the receive lane |
| rx_byte_done | output | 1 | Byte-complete pulse of the receive lane |

## Verification
The hardest case to reach is a lane that joins partway through a byte. It needs the shared position counter parked at a nonzero value while the lane is loaded and switched on. The stimulus gets there with a short counter load: three test-clock cycles advance another lane to position 3, and clocking then halts at zero. The test then reloads the counter, loads and enables a second lane, and checks that this lane sends five bits and raises its flag together with the first lane. A similar parked state is used to show that a single step moves the count but leaves the serial output where it was.

// File: rtl/tck_shift_pkg.sv
package tck_shift_pkg;

   // Per-cycle control broadcast from the clock/position logic to every lane
   typedef struct packed {
      logic fire;   // a test-clock cycle happens this system cycle
      logic wrap;   // this test-clock cycle is the last bit of a byte
   } tck_ctl_t;

endpackage

// File: rtl/tck_bit_ctrl.sv
module tck_bit_ctrl
   import tck_shift_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int BYTE_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_clr,
   input  logic             run_en,
   input  logic             step_req,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_load_val,
   output logic [CNT_W-1:0] cnt_q,
   output tck_ctl_t         ctl
);

   localparam int POS_W = $clog2(BYTE_W);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTE_W - 1);

   logic [POS_W-1:0] pos_q;
   logic             cnt_nz;
   logic             fire;
   logic             step_go;

   assign cnt_nz  = (cnt_q != '0);
   assign fire    = run_en && cnt_nz && !cnt_load && !sync_clr;
   assign step_go = step_req && !fire && cnt_nz && !cnt_load && !sync_clr;

   assign ctl.fire = fire;
   assign ctl.wrap = fire && (pos_q == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (sync_clr) begin
         cnt_q <= '0;
      end else if (cnt_load) begin
         cnt_q <= cnt_load_val;
      end else if (fire || step_go) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // shared position: power-of-two byte width lets the counter wrap naturally
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (sync_clr) begin
         pos_q <= '0;
      end else if (fire) begin
         pos_q <= pos_q + 1'b1;
      end
   end

   AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !cnt_load) |=> (cnt_q == '0)); // R2
   AST_CNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && cnt_q != '0 && !cnt_load && !sync_clr) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_load && !sync_clr) |=> (cnt_q == $past(cnt_load_val))); // R3
   AST_STEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req && !run_en && cnt_q != '0 && !cnt_load && !sync_clr)
      |=> (cnt_q == $past(cnt_q) - 1'b1 && pos_q == $past(pos_q))); // R4
   AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.wrap |=> (pos_q == '0)); // R6
   AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      sync_clr |=> (cnt_q == '0 && pos_q == '0)); // R10

endmodule

// File: rtl/tck_tx_lane.sv
module tck_tx_lane
   import tck_shift_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_clr,
   input  tck_ctl_t          ctl,
   input  logic              en,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   output logic              ser,
   output logic              done
);

   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] sh_next;
   logic              head;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign head    = sh_q[0];
         assign sh_next = {1'b0, sh_q[BYTE_W-1:1]};
      end else begin : g_msb
         assign head    = sh_q[BYTE_W-1];
         assign sh_next = {sh_q[BYTE_W-2:0], 1'b0};
      end
   endgenerate

   assign ser = en & head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         done <= 1'b0;
      end else if (sync_clr) begin
         sh_q <= '0;
         done <= 1'b0;
      end else begin
         done <= ctl.wrap && en;
         if (load) begin
            sh_q <= load_data;
         end else if (ctl.fire && en) begin
            sh_q <= sh_next;
         end
      end
   end

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load && !sync_clr) |=> $stable(sh_q)); // R7
   AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !sync_clr) |=> (sh_q == $past(load_data))); // R9
   AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

endmodule

// File: rtl/tck_rx_lane.sv
module tck_rx_lane
   import tck_shift_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_clr,
   input  tck_ctl_t          ctl,
   input  logic              en,
   input  logic              ser_in,
   output logic [BYTE_W-1:0] data,
   output logic              done
);

   logic [BYTE_W-1:0] sh_next;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sh_next = {ser_in, data[BYTE_W-1:1]};
      end else begin : g_msb
         assign sh_next = {data[BYTE_W-2:0], ser_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         done <= 1'b0;
      end else if (sync_clr) begin
         data <= '0;
         done <= 1'b0;
      end else begin
         done <= ctl.wrap && en;
         if (ctl.fire && en) begin
            data <= sh_next;
         end
      end
   end

   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !sync_clr) |=> $stable(data)); // R8
   AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

endmodule

// File: rtl/tck_shift_ctrl.sv
module tck_shift_ctrl
   import tck_shift_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int BYTE_W    = 8,
   parameter int NUM_TX    = 3,
   parameter bit LSB_FIRST = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sync_clr,
   input  logic                     run_en,
   input  logic                     step_req,
   input  logic                     cnt_load,
   input  logic [CNT_W-1:0]         cnt_load_val,
   output logic [CNT_W-1:0]         cnt_value,
   output logic                     tck_en,
   input  logic [NUM_TX-1:0]        tx_en,
   input  logic [NUM_TX-1:0]        tx_load,
   input  logic [NUM_TX*BYTE_W-1:0] tx_load_data,
   output logic [NUM_TX-1:0]        tx_serial,
   output logic [NUM_TX-1:0]        tx_byte_done,
   input  logic                     rx_en,
   input  logic                     rx_serial_in,
   output logic [BYTE_W-1:0]        rx_byte,
   output logic                     rx_byte_done
);

   // elaboration-time parameter checks
   generate
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
         $error("BYTE_W must be a power of two of at least 2");
      end
      if (NUM_TX < 1) begin : g_bad_lanes
         $error("NUM_TX must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   tck_ctl_t ctl;

   tck_bit_ctrl #(
      .CNT_W  (CNT_W),
      .BYTE_W (BYTE_W)
   ) u_bit_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync_clr     (sync_clr),
      .run_en       (run_en),
      .step_req     (step_req),
      .cnt_load     (cnt_load),
      .cnt_load_val (cnt_load_val),
      .cnt_q        (cnt_value),
      .ctl          (ctl)
   );

   assign tck_en = ctl.fire;

   generate
      for (genvar gi = 0; gi < NUM_TX; gi++) begin : g_tx
         tck_tx_lane #(
            .BYTE_W    (BYTE_W),
            .LSB_FIRST (LSB_FIRST)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_clr  (sync_clr),
            .ctl       (ctl),
            .en        (tx_en[gi]),
            .load      (tx_load[gi]),
            .load_data (tx_load_data[gi*BYTE_W +: BYTE_W]),
            .ser       (tx_serial[gi]),
            .done      (tx_byte_done[gi])
         );
      end
   endgenerate

   tck_rx_lane #(
      .BYTE_W    (BYTE_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_clr (sync_clr),
      .ctl      (ctl),
      .en       (rx_en),
      .ser_in   (rx_serial_in),
      .data     (rx_byte),
      .done     (rx_byte_done)
   );

   AST_TCK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      tck_en |-> (run_en && cnt_value != '0)); // R2
   AST_DONE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_byte_done && tx_en == {NUM_TX{1'b1}} && $past(tx_en) == {NUM_TX{1'b1}})
      |-> (tx_byte_done == {NUM_TX{1'b1}})); // R6

endmodule

// File: tb/tck_shift_ctrl_bench.sv
`timescale 1ns/1ps
module tck_shift_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_clr = 1'b0;
   logic        run_en = 1'b0;
   logic        step_req = 1'b0;
   logic        cnt_load = 1'b0;
   logic [31:0] cnt_load_val = '0;
   logic [31:0] cnt_value;
   logic        tck_en;
   logic [2:0]  tx_en = '0;
   logic [2:0]  tx_load = '0;
   logic [23:0] tx_load_data = '0;
   logic [2:0]  tx_serial;
   logic [2:0]  tx_byte_done;
   logic        rx_en = 1'b0;
   logic        rx_serial_in = 1'b0;
   logic [7:0]  rx_byte;
   logic        rx_byte_done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   tck_shift_ctrl u_tck_shift_ctrl (
      .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .run_en(run_en),
      .step_req(step_req), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
      .cnt_value(cnt_value), .tck_en(tck_en), .tx_en(tx_en), .tx_load(tx_load),
      .tx_load_data(tx_load_data), .tx_serial(tx_serial),
      .tx_byte_done(tx_byte_done), .rx_en(rx_en), .rx_serial_in(rx_serial_in),
      .rx_byte(rx_byte), .rx_byte_done(rx_byte_done)
   );

   localparam int NVEC = 6;
   localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h3C, 8'h01, 8'h80, 8'hFF, 8'h00};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // advance one clock; inputs are driven and outputs sampled at the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #0.5;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] a, b, c, rev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R1 reset state
      chk("R1 tck_en", {31'd0, tck_en}, 0);
      chk("R1 cnt", cnt_value, 0);
      chk("R1 serial", {29'd0, tx_serial}, 0);
      chk("R1 done", {28'd0, tx_byte_done, rx_byte_done}, 0);
      chk("R1 rx_byte", {24'd0, rx_byte}, 0);

      // table walk: R5, R6, R8, R2
      for (int v = 0; v < NVEC; v++) begin
         a = VEC[v];
         sync_clr = 1'b1;
         tick();
         sync_clr = 1'b0;
         tx_load = 3'b111;
         tx_load_data = {{a[3:0], a[7:4]}, ~a, a};
         tx_en = 3'b111;
         rx_en = 1'b1;
         cnt_load = 1'b1;
         cnt_load_val = 32'd8;
         #0.5;
         chk("R3 no tck while loading", {31'd0, tck_en}, 0);
         tick();
         tx_load = '0;
         cnt_load = 1'b0;
         run_en = 1'b1;
         for (int k = 0; k < 8; k++) begin
            rx_serial_in = a[7-k];
            #0.5;
            chk("R2 tck_en", {31'd0, tck_en}, 1);
            chk("R5 lane0 bit", {31'd0, tx_serial[0]}, {31'd0, a[k]});
            chk("R5 lane1 bit", {31'd0, tx_serial[1]}, {31'd0, ~a[k]});
            if (k < 7) chk("R6 no early done", {28'd0, tx_byte_done, rx_byte_done}, 0);
            tick();
         end
         for (int k = 0; k < 8; k++) rev[k] = a[7-k];
         chk("R6 all lanes done", {28'd0, tx_byte_done, rx_byte_done}, 32'hF);
         chk("R8 rx byte", {24'd0, rx_byte}, {24'd0, rev});
         chk("R2 count zero", cnt_value, 0);
         chk("R2 tck stops", {31'd0, tck_en}, 0);
         tick();
         chk("R6 done one cycle", {28'd0, tx_byte_done, rx_byte_done}, 0);
         run_en = 1'b0;
      end

      // R2 hold at zero with run requested
      run_en = 1'b1;
      repeat (3) tick();
      chk("R2 hold zero cnt", cnt_value, 0);
      chk("R2 hold zero tck", {31'd0, tck_en}, 0);
      run_en = 1'b0;

      // R4 single step
      a = 8'b1101_0110;
      sync_clr = 1'b1;
      tick();
      sync_clr = 1'b0;
      tx_load = 3'b001;
      tx_load_data = {16'h0, a};
      tx_en = 3'b001;
      rx_en = 1'b0;
      cnt_load = 1'b1;
      cnt_load_val = 32'd5;
      tick();
      tx_load = '0;
      cnt_load = 1'b0;
      step_req = 1'b1;
      #0.5;
      chk("R4 no tck on step", {31'd0, tck_en}, 0);
      tick();
      step_req = 1'b0;
      chk("R4 count stepped", cnt_value, 4);
      chk("R4 lane not moved", {31'd0, tx_serial[0]}, {31'd0, a[0]});
      run_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         chk("R4 bit after step", {31'd0, tx_serial[0]}, {31'd0, a[k]});
         tick();
      end
      chk("R4 count done", cnt_value, 0);
      // position is 4 here: no done flag yet
      chk("R6 no done mid byte", {29'd0, tx_byte_done}, 0);
      run_en = 1'b0;

      // R6 mid-byte enable at position 3, R7 disabled lane hold
      a = 8'h5A; b = 8'b1001_0111; c = 8'b1011_0101;
      sync_clr = 1'b1;
      tick();
      sync_clr = 1'b0;
      tx_load = 3'b011;
      tx_load_data = {8'h00, b, a};
      tx_en = 3'b001;
      cnt_load = 1'b1;
      cnt_load_val = 32'd3;
      tick();
      tx_load = '0;
      cnt_load = 1'b0;
      run_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         chk("R7 disabled lane is 0", {31'd0, tx_serial[1]}, 0);
         tick();
      end
      chk("R2 stop after 3", {31'd0, tck_en}, 0);
      tx_load = 3'b100;
      tx_load_data = {c, 16'h0};
      tx_en = 3'b101;
      cnt_load = 1'b1;
      cnt_load_val = 32'd5;
      tick();
      tx_load = '0;
      cnt_load = 1'b0;
      for (int k = 0; k < 5; k++) begin
         chk("R6 late lane bit", {31'd0, tx_serial[2]}, {31'd0, c[k]});
         chk("R6 early lane bit", {31'd0, tx_serial[0]}, {31'd0, a[k+3]});
         chk("R6 no done before boundary", {29'd0, tx_byte_done}, 0);
         tick();
      end
      chk("R6 five-bit first byte done", {29'd0, tx_byte_done}, 32'h5);
      tx_en = 3'b010;
      cnt_load = 1'b1;
      cnt_load_val = 32'd1;
      #0.5;
      chk("R7 held lane bit0", {31'd0, tx_serial[1]}, {31'd0, b[0]});
      tick();
      cnt_load = 1'b0;
      tick();
      chk("R7 held lane bit1", {31'd0, tx_serial[1]}, {31'd0, b[1]});
      run_en = 1'b0;

      // R9 load beats shift in the same cycle
      tx_en = 3'b001;
      cnt_load = 1'b1;
      cnt_load_val = 32'd2;
      tick();
      cnt_load = 1'b0;
      run_en = 1'b1;
      tx_load = 3'b001;
      tx_load_data = {16'h0, 8'h0E};
      tick();
      tx_load = '0;
      run_en = 1'b0;
      chk("R9 load wins over shift", {31'd0, tx_serial[0]}, 0);
      run_en = 1'b1;
      tick();
      run_en = 1'b0;
      chk("R9 next bit of loaded byte", {31'd0, tx_serial[0]}, 1);

      // R10 clear beats load
      sync_clr = 1'b1;
      tx_load = 3'b111;
      tx_load_data = 24'hFFFFFF;
      cnt_load = 1'b1;
      cnt_load_val = 32'd9;
      tx_en = 3'b111;
      tick();
      sync_clr = 1'b0;
      tx_load = '0;
      cnt_load = 1'b0;
      chk("R10 lanes cleared", {29'd0, tx_serial}, 0);
      chk("R10 count cleared", cnt_value, 0);
      chk("R10 flags cleared", {28'd0, tx_byte_done, rx_byte_done}, 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule